// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window through which a host processor hands work to a controller core and collects the answer. The host loads up to sixteen bytes of arguments into an outbound buffer and then writes a command word. That write marks the mailbox busy and sends a one-cycle doorbell to the controller. The controller sees the latched command and the outbound buffer as plain parallel outputs. It returns result words over a valid/ready stream into an inbound buffer, then signals completion with an error flag, an 8-bit error code and an initiator id.

The host polls the status word for the busy flag, or it sets the interrupt-request bit in the command so that completion raises a level interrupt. It clears that interrupt by writing a one to bit 2 of the status word. The inbound buffer can be read as whole 32-bit words or as single bytes, with byte 0 in the least significant position.

The inbound stream applies back-pressure through `ctl_fill_ready`, which is high exactly while a command is outstanding. A beat moves on any clock edge where `ctl_fill_valid` and `ctl_fill_ready` are both high. Beats offered while the mailbox is idle are not taken, and the controller must hold them until it sees ready.

Top module: `ipc_mailbox`

## Requirements
- R1: A host write to offset 0x00 while idle is accepted on that clock edge. Busy is set, the error flag, error code and initiator id are cleared, the whole word appears on `ctl_cmd`, and its bits 15:12 become the status command id.
- R2: An accepted command produces exactly one `ctl_doorbell` pulse, high during the cycle that follows the write edge.
- R3: A command write while busy is ignored: no doorbell is sent, and `ctl_cmd` and the status word keep their values.
- R4: Host writes to offset 0x80+4k (k = 0..3) while idle store word k, which appears on `ctl_wbuf[32k+31:32k]`. Such writes are ignored while busy. Reads of the command offset and of the outbound buffer return 0.
- R5: `ctl_fill_ready` equals busy. A beat with valid and ready both high stores `ctl_fill_data` into inbound word `ctl_fill_idx`. A beat offered while idle leaves the inbound buffer unchanged.
- R6: `ctl_done` while busy clears busy on that edge and captures the error flag from `ctl_err`, together with `ctl_err_code` and `ctl_init_id`. `ctl_done` while idle changes nothing.
- R7: If bit 8 (IOC) of the accepted command is 1, completion sets `host_irq`, which stays high until acknowledged. If that bit is 0, completion leaves `host_irq` low.
- R8: A host write to offset 0x04 with bit 2 set clears `host_irq`. A completion that requests the interrupt in the same cycle wins, and `host_irq` stays high.
- R9: The status word at offset 0x04 reads as follows: bit 0 busy, bit 1 error, bit 2 interrupt pending, bit 3 zero, bits 7:4 command id, bits 15:8 initiator id, bits 23:16 error code, bits 31:24 zero.
- R10: With `host_byte` = 0, reads at offsets 0x90..0x9F return inbound word addr[3:2]. With `host_byte` = 1, they return byte addr[1:0] of that word, taken little-endian and zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host byte address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_byte | input | 1 | Byte-wide read of the inbound buffer |
| host_rdata | output | 32 | Host read data (combinational) |
| host_irq | output | 1 | Completion interrupt, level |
| ctl_doorbell | output | 1 | One-cycle new-command pulse |
| ctl_cmd | output | 32 | Latched command word |
| ctl_wbuf | output | 128 | Outbound buffer, word k at bits 32k+31:32k |
| ctl_fill_valid | input | 1 | Inbound beat valid |
| ctl_fill_ready | output | 1 | Inbound beat ready (busy) |
| ctl_fill_idx | input | 2 | Inbound word index |
| ctl_fill_data | input | 32 | Inbound word data |
| ctl_done | input | 1 | Command completion pulse |
| ctl_err | input | 1 | Completion error flag |
| ctl_err_code | input | 8 | Completion error code |
| ctl_init_id | input | 8 | Completion initiator id |

## Verification
Two events can land on the same edge: the controller completing a command that requests an interrupt, and the host acknowledging the interrupt left over from the previous command. The bench first leaves an interrupt pending. It then issues a second command with IOC set and drives `ctl_done` and the status write with bit 2 set in one cycle. The test passes only if `host_irq` is still high afterwards. A later acknowledge on its own must then clear it. A second pairing is also checked: a command write that arrives while busy must leave the pending command untouched.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_OBUF = 8'h80;
  localparam logic [7:0] OFS_IBUF = 8'h90;
  localparam int ACK_BIT = 2;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] size;
    logic [3:0] cmd_id;
    logic [2:0] rsv_lo;
    logic       ioc;
    logic [7:0] opcode;
  } cmd_word_t;
endpackage

// File: rtl/ipc_mbx_buf.sv
module ipc_mbx_buf #(
  parameter int NWORDS = 4,
  parameter int DW     = 32,
  localparam int IW    = $clog2(NWORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic [IW-1:0]        rd_idx,
  output logic [DW-1:0]        rd_word,
  output logic [NWORDS*DW-1:0] flat
);
  logic [DW-1:0] mem [NWORDS];

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                               mem[k] <= '0;
      else if (wr_en && wr_idx == IW'(k))       mem[k] <= wr_data;
    end
    assign flat[k*DW +: DW] = mem[k];
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/ipc_mbx_ctrl.sv
module ipc_mbx_ctrl
  import ipc_mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_data,
  input  logic        ack_wr,
  input  logic        done,
  input  logic        done_err,
  input  logic [7:0]  done_code,
  input  logic [7:0]  done_init,
  output logic        busy,
  output logic        err_flag,
  output logic        irq,
  output logic        doorbell,
  output logic [31:0] cmd_q,
  output logic [7:0]  err_code,
  output logic [7:0]  init_id
);
  cmd_word_t cmd_s;
  logic accept, finish;

  assign cmd_s  = cmd_word_t'(cmd_q);
  assign accept = cmd_wr && !busy;
  assign finish = done && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err_flag <= 1'b0;
      irq      <= 1'b0;
      doorbell <= 1'b0;
      cmd_q    <= '0;
      err_code <= '0;
      init_id  <= '0;
    end else begin
      doorbell <= accept;
      if (accept) begin
        busy     <= 1'b1;
        err_flag <= 1'b0;
        err_code <= '0;
        init_id  <= '0;
        cmd_q    <= cmd_data;
      end else if (finish) begin
        busy     <= 1'b0;
        err_flag <= done_err;
        err_code <= done_code;
        init_id  <= done_init;
      end
      // a fresh completion outranks an acknowledge of the previous one
      if (finish && cmd_s.ioc) irq <= 1'b1;
      else if (ack_wr)         irq <= 1'b0;
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbx_pkg::*;
#(
  parameter int NWORDS = 4,
  localparam int IW    = $clog2(NWORDS),
  localparam int SPAN  = NWORDS * 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           host_addr,
  input  logic                 host_we,
  input  logic [31:0]          host_wdata,
  input  logic                 host_byte,
  output logic [31:0]          host_rdata,
  output logic                 host_irq,
  output logic                 ctl_doorbell,
  output logic [31:0]          ctl_cmd,
  output logic [NWORDS*32-1:0] ctl_wbuf,
  input  logic                 ctl_fill_valid,
  output logic                 ctl_fill_ready,
  input  logic [IW-1:0]        ctl_fill_idx,
  input  logic [31:0]          ctl_fill_data,
  input  logic                 ctl_done,
  input  logic                 ctl_err,
  input  logic [7:0]           ctl_err_code,
  input  logic [7:0]           ctl_init_id
);
  logic        busy, err_flag;
  logic [7:0]  err_code, init_id;
  logic        in_obuf, in_ibuf;
  logic [31:0] obuf_word, ibuf_word, status;
  logic [7:0]  ibuf_byte;
  cmd_word_t   cmd_s;

  assign in_obuf = (int'(host_addr) >= int'(OFS_OBUF)) && (int'(host_addr) < int'(OFS_OBUF) + SPAN);
  assign in_ibuf = (int'(host_addr) >= int'(OFS_IBUF)) && (int'(host_addr) < int'(OFS_IBUF) + SPAN);

  ipc_mbx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(host_we && host_addr == OFS_CMD), .cmd_data(host_wdata),
    .ack_wr(host_we && host_addr == OFS_STAT && host_wdata[ACK_BIT]),
    .done(ctl_done), .done_err(ctl_err), .done_code(ctl_err_code), .done_init(ctl_init_id),
    .busy(busy), .err_flag(err_flag), .irq(host_irq), .doorbell(ctl_doorbell),
    .cmd_q(ctl_cmd), .err_code(err_code), .init_id(init_id)
  );

  ipc_mbx_buf #(.NWORDS(NWORDS), .DW(32)) u_obuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_we && in_obuf && !busy), .wr_idx(host_addr[IW+1:2]), .wr_data(host_wdata),
    .rd_idx(host_addr[IW+1:2]), .rd_word(obuf_word), .flat(ctl_wbuf)
  );

  logic [NWORDS*32-1:0] ibuf_flat;
  ipc_mbx_buf #(.NWORDS(NWORDS), .DW(32)) u_ibuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ctl_fill_valid && ctl_fill_ready), .wr_idx(ctl_fill_idx), .wr_data(ctl_fill_data),
    .rd_idx(host_addr[IW+1:2]), .rd_word(ibuf_word), .flat(ibuf_flat)
  );

  assign ctl_fill_ready = busy;
  assign cmd_s          = cmd_word_t'(ctl_cmd);
  assign status         = {8'h00, err_code, init_id, cmd_s.cmd_id, 1'b0, host_irq, err_flag, busy};
  assign ibuf_byte      = ibuf_word[{host_addr[1:0], 3'b000} +: 8];

  always_comb begin
    host_rdata = '0;
    if (host_addr == OFS_STAT)  host_rdata = status;
    else if (in_ibuf)           host_rdata = host_byte ? {24'h0, ibuf_byte} : ibuf_word;
  end

  logic unused_ok;
  assign unused_ok = ^{obuf_word, ibuf_flat};
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  host_addr,
  input logic        host_we,
  input logic [31:0] host_wdata,
  input logic        host_irq,
  input logic        ctl_doorbell,
  input logic [31:0] ctl_cmd,
  input logic        ctl_fill_ready,
  input logic        ctl_done
);
  logic cmd_wr;
  assign cmd_wr = host_we && host_addr == 8'h00;

  assert_cmd_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !ctl_fill_ready) |=> (ctl_fill_ready && ctl_cmd == $past(host_wdata)));

  assert_doorbell_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_doorbell |-> $past(cmd_wr && !ctl_fill_ready));

  assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && ctl_fill_ready) |=> (!ctl_doorbell && $stable(ctl_cmd)));

  assert_busy_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_fill_ready) |-> $past(ctl_done));

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(ctl_done && ctl_fill_ready && ctl_cmd[8]));

  assert_irq_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_done && ctl_fill_ready && ctl_cmd[8]) |=> host_irq);
endmodule

bind ipc_mailbox ipc_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
  .host_wdata(host_wdata), .host_irq(host_irq), .ctl_doorbell(ctl_doorbell),
  .ctl_cmd(ctl_cmd), .ctl_fill_ready(ctl_fill_ready), .ctl_done(ctl_done)
);

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] host_addr = 0;
  logic host_we = 0, host_byte = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic host_irq, ctl_doorbell, ctl_fill_ready;
  logic [31:0] ctl_cmd;
  logic [127:0] ctl_wbuf;
  logic ctl_fill_valid = 0, ctl_done = 0, ctl_err = 0;
  logic [1:0] ctl_fill_idx = 0;
  logic [31:0] ctl_fill_data = 0;
  logic [7:0] ctl_err_code = 0, ctl_init_id = 0;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox u0 (.*);

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, logic b, output logic [31:0] v);
    host_addr = a; host_byte = b; #1; v = host_rdata; host_byte = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk); host_we = 0;
  endtask

  task automatic fill(logic [1:0] i, logic [31:0] d);
    @(negedge clk); ctl_fill_valid = 1; ctl_fill_idx = i; ctl_fill_data = d;
    @(negedge clk); ctl_fill_valid = 0;
  endtask

  task automatic finish_cmd(logic e, logic [7:0] code, logic [7:0] init);
    @(negedge clk); ctl_done = 1; ctl_err = e; ctl_err_code = code; ctl_init_id = init;
    @(negedge clk); ctl_done = 0; ctl_err = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    rd(8'h04, 0, v); chk("R9 reset status", v, 0);
    chk("R7 reset irq", host_irq, 0);
    chk("R2 reset doorbell", ctl_doorbell, 0);
    chk("R5 reset ready", ctl_fill_ready, 0);
  endtask

  task automatic t_accept();
    logic [31:0] v;
    wr(8'h80, 32'hDDCCBBAA); wr(8'h84, 32'h11223344);
    chk("R4 obuf words", ctl_wbuf[63:0], 64'h11223344_DDCCBBAA);
    rd(8'h80, 0, v); chk("R4 obuf reads zero", v, 0);
    wr(8'h00, 32'h0008_5142);
    chk("R2 doorbell pulse", ctl_doorbell, 1);
    chk("R1 cmd latched", ctl_cmd, 32'h0008_5142);
    rd(8'h00, 0, v); chk("R4 cmd reads zero", v, 0);
    rd(8'h04, 0, v); chk("R9 R1 busy status", v, 32'h51);
    @(negedge clk); chk("R2 doorbell single", ctl_doorbell, 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    wr(8'h00, 32'h0000_3007);
    chk("R3 no doorbell", ctl_doorbell, 0);
    chk("R3 cmd kept", ctl_cmd, 32'h0008_5142);
    rd(8'h04, 0, v); chk("R3 status kept", v, 32'h51);
    wr(8'h80, 32'hFFFFFFFF);
    chk("R4 obuf write while busy", ctl_wbuf[31:0], 32'hDDCCBBAA);
  endtask

  task automatic t_fill_done();
    logic [31:0] v;
    chk("R5 ready while busy", ctl_fill_ready, 1);
    fill(2'd0, 32'h44332211); fill(2'd3, 32'h88776655);
    finish_cmd(0, 8'h00, 8'h3C);
    chk("R7 irq on ioc", host_irq, 1);
    rd(8'h04, 0, v); chk("R6 R9 status after done", v, 32'h0000_3C54);
    rd(8'h90, 0, v); chk("R10 word 0", v, 32'h44332211);
    rd(8'h9C, 0, v); chk("R10 word 3", v, 32'h88776655);
    rd(8'h91, 1, v); chk("R10 byte 1", v, 32'h22);
    rd(8'h9F, 1, v); chk("R10 byte 15", v, 32'h88);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(8'h04, 32'h4);
    chk("R8 ack clears irq", host_irq, 0);
    rd(8'h04, 0, v); chk("R8 status after ack", v, 32'h0000_3C50);
  endtask

  task automatic t_idle_ignore();
    logic [31:0] v;
    fill(2'd0, 32'hDEADBEEF);
    rd(8'h90, 0, v); chk("R5 idle fill ignored", v, 32'h44332211);
    finish_cmd(1, 8'h77, 8'h11);
    rd(8'h04, 0, v); chk("R6 idle done ignored", v, 32'h0000_3C50);
    chk("R7 idle done no irq", host_irq, 0);
  endtask

  task automatic t_error();
    logic [31:0] v;
    wr(8'h00, 32'h0000_2099);
    rd(8'h04, 0, v); chk("R1 ids cleared on accept", v, 32'h21);
    finish_cmd(1, 8'hA5, 8'h07);
    rd(8'h04, 0, v); chk("R6 error captured", v, 32'h00A5_0722);
    chk("R7 no irq without ioc", host_irq, 0);
    wr(8'h00, 32'h0000_7100);
    rd(8'h04, 0, v); chk("R1 error cleared", v, 32'h71);
    finish_cmd(0, 8'h00, 8'h01);
    rd(8'h04, 0, v); chk("R6 clean completion", v, 32'h0000_0174);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(8'h00, 32'h0000_6100);
    rd(8'h04, 0, v); chk("R9 pending irq kept", v, 32'h65);
    @(negedge clk);
    ctl_done = 1; ctl_init_id = 8'h02; ctl_err_code = 0;
    host_addr = 8'h04; host_wdata = 32'h4; host_we = 1;
    @(negedge clk); ctl_done = 0; host_we = 0;
    chk("R8 completion beats ack", host_irq, 1);
    rd(8'h04, 0, v); chk("R8 status same cycle", v, 32'h0000_0264);
    wr(8'h04, 32'h4);
    chk("R8 later ack clears", host_irq, 0);
    rd(8'h04, 0, v); chk("R8 status final", v, 32'h0000_0260);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_accept();
    t_busy_ignore();
    t_fill_done();
    t_ack();
    t_idle_ignore();
    t_error();
    t_same_cycle();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule